// File: doc/BRIEF.md
# Sprite and Playfield Collision Detector

This block watches one pixel per clock of a display made of six bitplanes and eight sprites, and records which visible objects overlapped. The eight sprites form four groups: group k is always driven by sprite 2k, and sprite 2k+1 can be merged into it by a control bit. The bitplanes form two playfields. Planes 1, 3 and 5 make the first playfield and planes 2, 4 and 6 make the second.

A playfield is present on a pixel when every one of its enabled planes carries its programmed match value. A playfield whose planes are all disabled is therefore present on every pixel. Fifteen collision flags, one for each pair of objects, are accumulated as sticky bits while the display-active input is high.

Software reads the flags through a read strobe. The read returns the flags and clears them at the same time. A hit that occurs in the cycle of the read is carried into the next read and is not lost.

Top module: `coll_det`

## Requirements
- R1: After reset the result output `res_o` is 0 and the control register is 0.
- R2: When `ctrl_we_i` is high, `ctrl_wdata_i` is loaded into the control register. The new value first affects detection in the following cycle; the pixel of the write cycle uses the old value.
- R3: Sprite group k (k = 0..3) is active when sprite 2k is active. It is also active when sprite 2k+1 is active and control bit 12+k is 1.
- R4: Control bits 6..11 enable bitplanes 1..6 for matching, and control bits 0..5 hold the required values of bitplanes 1..6. Plane n is carried on `plane_i[n-1]`.
- R5: Playfield 1 (planes 1, 3, 5) is present when each of its enabled planes equals its match value, and likewise playfield 2 (planes 2, 4, 6). A disabled plane never blocks a match, so a playfield with no enabled plane is always present.
- R6: Bit 0 flags playfield 1 against playfield 2. Bits 1..4 flag playfield 1 against groups 0..3, and bits 5..8 flag playfield 2 against groups 0..3.
- R7: Bits 9..14 flag group pairs in this order: 0-1, 0-2, 0-3, 1-2, 1-3, 2-3.
- R8: Bit 15 of `res_o` is always 0.
- R9: Between reads, each flag is the OR of its hits over every cycle since the last read or reset.
- R10: `res_o` shows the accumulated flags. After a cycle with `rd_i` high, the flags hold only the hits of that cycle.
- R11: While `disp_act_i` is low, no new flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 16 | Control register write data |
| disp_act_i | input | 1 | Detection enable; high while the display is active |
| plane_i | input | 6 | Bitplane bits of the current pixel; bit n-1 is plane n |
| spr_i | input | 8 | Active bits of sprites 0..7 |
| rd_i | input | 1 | Read strobe; clears the flags after this cycle |
| res_o | output | 16 | Accumulated collision flags |

## Verification
The bench checks the case where every plane is disabled, since a design that treated "no enabled plane" as "absent" would never flag a playfield hit. It also checks an odd sprite with its merge bit off, which a careless design would still flag. Hits that arrive in the same cycle as a read are checked: a design that cleared after merging would drop them. A control write is checked on the pixel it lands with, where a forwarding design would use the new value one cycle early. A long random run compares every cycle against a behavioural model, which catches any swap in the pair-bit order or in the odd and even plane split.

// File: rtl/coll_pkg.sv
package coll_pkg;
  // Bit position of the group-pair flag (a<b), pairs in lexicographic order after the playfield flags
  function automatic int unsigned pair_bit(input int unsigned a, input int unsigned b,
                                           input int unsigned ng);
    return 1 + 2 * ng + a * ng - (a * (a + 1)) / 2 + (b - a - 1);
  endfunction

  function automatic int unsigned used_bits(input int unsigned ng);
    return 1 + 2 * ng + (ng * (ng - 1)) / 2;
  endfunction
endpackage

// File: rtl/coll_pf_match.sv
module coll_pf_match #(
  parameter int unsigned NP = 6
) (
  input  logic [NP-1:0] plane_i,
  input  logic [NP-1:0] en_i,
  input  logic [NP-1:0] mv_i,
  output logic [1:0]    pf_o
);
  logic [NP-1:0] miss;
  logic [NP-1:0] miss_odd;
  logic [NP-1:0] miss_even;

  for (genvar i = 0; i < NP; i++) begin : g_plane
    assign miss[i] = en_i[i] & (plane_i[i] ^ mv_i[i]);
    // index 0 is plane 1 (playfield 1)
    if ((i % 2) == 0) begin : g_odd
      assign miss_odd[i]  = miss[i];
      assign miss_even[i] = 1'b0;
    end else begin : g_even
      assign miss_odd[i]  = 1'b0;
      assign miss_even[i] = miss[i];
    end
  end

  assign pf_o[0] = ~|miss_odd;
  assign pf_o[1] = ~|miss_even;
endmodule

// File: rtl/coll_spr_group.sv
module coll_spr_group #(
  parameter int unsigned NG = 4
) (
  input  logic [2*NG-1:0] spr_i,
  input  logic [NG-1:0]   merge_i,
  output logic [NG-1:0]   grp_o
);
  for (genvar k = 0; k < NG; k++) begin : g_grp
    assign grp_o[k] = spr_i[2*k] | (merge_i[k] & spr_i[2*k+1]);
  end
endmodule

// File: rtl/coll_hit_map.sv
module coll_hit_map
  import coll_pkg::*;
#(
  parameter int unsigned NG = 4,
  localparam int unsigned UW = used_bits(NG)
) (
  input  logic [1:0]    pf_i,
  input  logic [NG-1:0] grp_i,
  output logic [UW-1:0] hit_o
);
  assign hit_o[0] = pf_i[0] & pf_i[1];

  for (genvar k = 0; k < NG; k++) begin : g_pf
    assign hit_o[1 + k]      = pf_i[0] & grp_i[k];
    assign hit_o[1 + NG + k] = pf_i[1] & grp_i[k];
  end

  for (genvar a = 0; a < NG; a++) begin : g_a
    for (genvar b = a + 1; b < NG; b++) begin : g_b
      assign hit_o[pair_bit(a, b, NG)] = grp_i[a] & grp_i[b];
    end
  end
endmodule

// File: rtl/coll_det.sv
module coll_det
  import coll_pkg::*;
#(
  parameter int unsigned NP    = 6,
  parameter int unsigned NG    = 4,
  parameter int unsigned RES_W = 16,
  localparam int unsigned CW   = NG + 2 * NP,
  localparam int unsigned UW   = used_bits(NG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [CW-1:0]    ctrl_wdata_i,
  input  logic             disp_act_i,
  input  logic [NP-1:0]    plane_i,
  input  logic [2*NG-1:0]  spr_i,
  input  logic             rd_i,
  output logic [RES_W-1:0] res_o
);
  logic [CW-1:0]    ctrl_q;
  logic [RES_W-1:0] flags_q;
  logic [1:0]       pf;
  logic [NG-1:0]    grp;
  logic [UW-1:0]    hit;
  logic [RES_W-1:0] hit_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
  end

  coll_pf_match #(.NP(NP)) u_pf (
    .plane_i (plane_i),
    .en_i    (ctrl_q[2*NP-1:NP]),
    .mv_i    (ctrl_q[NP-1:0]),
    .pf_o    (pf)
  );

  coll_spr_group #(.NG(NG)) u_grp (
    .spr_i   (spr_i),
    .merge_i (ctrl_q[CW-1:2*NP]),
    .grp_o   (grp)
  );

  coll_hit_map #(.NG(NG)) u_map (
    .pf_i  (pf),
    .grp_i (grp),
    .hit_o (hit)
  );

  assign hit_ext = disp_act_i ? RES_W'(hit) : '0;

  // read clears history but keeps hits of the read cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= '0;
    else if (rd_i) flags_q <= hit_ext;
    else           flags_q <= flags_q | hit_ext;
  end

  assign res_o = flags_q;
endmodule

// File: rtl/coll_det_chk.sv
module coll_det_chk #(
  parameter int unsigned NP    = 6,
  parameter int unsigned NG    = 4,
  parameter int unsigned RES_W = 16,
  parameter int unsigned CW    = NG + 2 * NP
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic [CW-1:0]    ctrl_wdata_i,
  input logic             disp_act_i,
  input logic [NP-1:0]    plane_i,
  input logic [2*NG-1:0]  spr_i,
  input logic             rd_i,
  input logic [RES_W-1:0] res_o
);
  p_spare_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o[RES_W-1] == 1'b0);

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!disp_act_i && !rd_i) |=> $stable(res_o));

  p_idle_read_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!disp_act_i && rd_i) |=> (res_o == '0));

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((res_o & $past(res_o)) == $past(res_o)));

  p_no_sprite_no_group_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && spr_i == '0) |=> (res_o[RES_W-2:1] == $past(res_o[RES_W-2:1])));
endmodule

bind coll_det coll_det_chk #(.NP(NP), .NG(NG), .RES_W(RES_W), .CW(CW)) u_chk (.*);

// File: tb/tb_coll_det.sv
module tb_coll_det;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [15:0] ctrl_wdata_i = '0;
  logic        disp_act_i = 1'b0;
  logic [5:0]  plane_i = '0;
  logic [7:0]  spr_i = '0;
  logic        rd_i = 1'b0;
  logic [15:0] res_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  logic [15:0] m_ctrl = '0;
  logic [15:0] m_flags = '0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  coll_det dut (.*);

  function automatic logic [15:0] model_hits(input logic [15:0] c, input logic [5:0] pl,
                                             input logic [7:0] sp, input logic act);
    logic [15:0] r;
    logic [3:0] g;
    logic pf1, pf2;
    int pa [6], pb [6];
    r = '0;
    pf1 = 1'b1;
    pf2 = 1'b1;
    for (int k = 0; k < 4; k++) g[k] = sp[2*k] | (c[12+k] & sp[2*k+1]);
    for (int p = 1; p <= 6; p++)
      if (c[5+p] && (pl[p-1] != c[p-1])) begin
        if (p % 2 == 1) pf1 = 1'b0; else pf2 = 1'b0;
      end
    r[0] = pf1 & pf2;
    for (int k = 0; k < 4; k++) begin
      r[1+k] = pf1 & g[k];
      r[5+k] = pf2 & g[k];
    end
    pa = '{0, 0, 0, 1, 1, 2};
    pb = '{1, 2, 3, 2, 3, 3};
    for (int i = 0; i < 6; i++) r[9+i] = g[pa[i]] & g[pb[i]];
    if (!act) r = '0;
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%04h exp=%04h", req, got, exp);
    end
  endtask

  task automatic cyc(input string req, input logic we, input logic [15:0] wd, input logic act,
                     input logic [5:0] pl, input logic [7:0] sp, input logic rd);
    logic [15:0] h;
    ctrl_we_i = we; ctrl_wdata_i = wd; disp_act_i = act;
    plane_i = pl; spr_i = sp; rd_i = rd;
    @(posedge clk_i);
    h = model_hits(m_ctrl, pl, sp, act);
    m_flags = rd ? h : (m_flags | h);
    if (we) m_ctrl = wd;
    @(negedge clk_i);
    chk(req, res_o, m_flags);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", res_o, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", res_o, 16'h0000);
    // all planes disabled: both playfields present -> bit 0
    cyc("R5", 0, 0, 1, 6'h2A, 8'h00, 0);
    chk("R5", res_o, 16'h0001);
    // read clears, then idle cycle keeps zero
    cyc("R10", 0, 0, 0, 0, 0, 1);
    chk("R10", res_o, 16'h0000);
    // sprite 1 without merge: no group hit
    cyc("R3", 0, 0, 1, 0, 8'h02, 1);
    chk("R3", res_o, 16'h0001);
    // write merge for sprite 1; write cycle still uses old ctrl
    cyc("R2", 1, 16'h1000, 1, 0, 8'h02, 1);
    chk("R2", res_o, 16'h0001);
    cyc("R3", 0, 0, 1, 0, 8'h02, 1);
    chk("R3", res_o, 16'h0023);
    // display inactive: nothing new
    cyc("R11", 0, 0, 0, 0, 0, 1);
    cyc("R11", 0, 0, 0, 6'h3F, 8'hFF, 0);
    chk("R11", res_o, 16'h0000);
    // enable plane 1 with match 1; plane 1 at 0 -> pf1 absent
    cyc("R4", 1, 16'h0041, 0, 0, 0, 0);
    cyc("R4", 0, 0, 1, 6'h00, 8'h01, 0);
    chk("R4", res_o, 16'h0020);
    cyc("R4", 0, 0, 1, 6'h01, 8'h01, 1);
    chk("R6", res_o, 16'h0023);
    // group pairs 0-3 and 2-3, planes mismatched
    cyc("R7", 1, 16'h0FC0, 0, 0, 0, 1);
    cyc("R7", 0, 0, 1, 6'h3F, 8'h41, 1);
    chk("R7", res_o, 16'h0800);
    cyc("R9", 0, 0, 1, 6'h3F, 8'h50, 0);
    chk("R9", res_o, 16'h4800);
    // hit in read cycle is kept
    cyc("R10", 0, 0, 1, 6'h3F, 8'h05, 1);
    chk("R10", res_o, 16'h0200);
    chk("R8", res_o[15], 1'b0);
    // random run against the model
    for (int i = 0; i < 3000; i++) begin
      cyc("R6", ($urandom % 16) == 0, 16'($urandom), ($urandom % 8) != 0,
          6'($urandom), 8'($urandom & $urandom), ($urandom % 8) == 0);
      if (res_o[15] !== 1'b0) chk("R8", res_o, m_flags & 16'h7FFF);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule